// File: doc/BRIEF.md
# Indirect Test Register Access Window

This block gives a narrow management bus a window into a bank of up to 32 internal test and configuration registers. The registers differ in width, and none is wider than 32 bits. Software never addresses the bank directly. It works through four management registers: a control word, a write-data holding register and two read-only readback halves.

A write to the control word can raise a one-shot read command, a one-shot write command, or both at once. Each command bit reads as 1 for the single cycle after the bus write. On the next clock edge the command runs and the bit clears itself. Commands take effect only while the control word's mode-enable bit is set.

A read command copies the selected internal register into the readback pair. The low 16 bits go to the low half. The upper bits go to the high half, starting from bit 16, and are zero-filled for narrow registers. A write command loads the low 16 bits of the selected internal register from the holding register. Any bits above 16 keep their old value.

The bus is a plain synchronous address, data and write-strobe port, and its read data is combinational. The management addresses are: control 20, readback-low 21, readback-high 22 and write-data 23. Internal register `i` is `((7*i+4) mod 32)+1` bits wide. It resets to `{16'hC0DE ^ i, 16'h5A5A + i}`, cut to that width.

Top module: `tst_window`

## Requirements
- R1: After reset, the control word, the write-data register and both readback registers all read 0.
- R2: The control word layout is: bit 15 read command, bit 14 write command, bits 13:11 reserved, bit 10 mode enable, bits 9:5 read index, bits 4:0 write index. The reserved bits always read 0, so writing 16'h3FFF reads back 16'h07FF.
- R3: A command bit written as 1 reads as 1 in the cycle after the bus write. After the next clock edge it reads 0, and by then the command has taken effect.
- R4: A write command with mode enabled loads the low 16 bits of the write-data register into the internal register at the write index. The value is cut to that register's width, and bits at or above 16 are kept.
- R5: A read command with mode enabled on a register of 16 bits or fewer puts its value in readback-low from bit 0 and sets readback-high to 0.
- R6: A read command on a register wider than 16 bits puts bits 15:0 in readback-low and bits 31:16 in readback-high.
- R7: With mode disabled, both commands do nothing. The command bits still clear, the bank is unchanged and the readback registers keep their value.
- R8: The readback registers keep their snapshot until the next read command, even if the internal register changes in the meantime.
- R9: When read and write commands are set in the same bus write, the write is done first, so the readback returns the newly written value.
- R10: The write-data register reads back what was written. Bus writes to the readback addresses have no effect.
- R11: Bits of an internal register above its width are never stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Management register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |

## Verification
The bench writes into registers that are 1, 5, 15, 16, 19, 30 and 32 bits wide. A design that masked or zero-filled the wrong way would show stray high bits in a narrow register, or would lose the reset value of the upper bits of a wide one. The bench samples the control word in the cycle just after a command is written and again one cycle later. This catches command bits that never clear, and commands that run a cycle early or late. It issues commands with mode disabled and then reads the bank back. A block that leaked those commands would show either a corrupted register or a changed snapshot. A combined read-and-write command on the same index tells write-first ordering apart from a design that returns the stale value.

// File: rtl/tstwin_pkg.sv
package tstwin_pkg;
  localparam int unsigned BUS_W    = 16;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned MAXW     = 32;
  localparam int unsigned W_STRIDE = 7;
  localparam int unsigned W_OFFSET = 4;

  // management register addresses
  localparam logic [ADDR_W-1:0] CTRL_ADR = 5'd20;
  localparam logic [ADDR_W-1:0] RBLO_ADR = 5'd21;
  localparam logic [ADDR_W-1:0] RBHI_ADR = 5'd22;
  localparam logic [ADDR_W-1:0] WDAT_ADR = 5'd23;

  // control word bit positions
  localparam int unsigned RD_BIT   = 15;
  localparam int unsigned WR_BIT   = 14;
  localparam int unsigned MODE_BIT = 10;
  localparam int unsigned RIDX_LSB = 5;
  localparam int unsigned WIDX_LSB = 0;

  function automatic int unsigned reg_width(int unsigned idx);
    return ((idx * W_STRIDE + W_OFFSET) % MAXW) + 1;
  endfunction

  function automatic logic [MAXW-1:0] width_mask(int unsigned w);
    logic [MAXW:0] m;
    m = ({{MAXW{1'b0}}, 1'b1} << w) - 1'b1;
    return m[MAXW-1:0];
  endfunction

  function automatic logic [MAXW-1:0] init_value(int unsigned idx);
    logic [31:0] v;
    v[15:0]  = 16'h5A5A + idx[15:0];
    v[31:16] = 16'hC0DE ^ idx[15:0];
    return MAXW'(v) & width_mask(reg_width(idx));
  endfunction

  // replace the low bus-width bits, keep the rest, cut to width
  function automatic logic [MAXW-1:0] merge_low(logic [MAXW-1:0] old,
                                               logic [BUS_W-1:0] wd,
                                               logic [MAXW-1:0] mask);
    logic [MAXW-1:0] t;
    t = old;
    t[BUS_W-1:0] = wd;
    return t & mask;
  endfunction
endpackage

// File: rtl/tstwin_ctrl.sv
module tstwin_ctrl
  import tstwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  ctrl_word,
  output logic [BUS_W-1:0]  wdata_q,
  output logic              mode_en,
  output logic [ADDR_W-1:0] ridx,
  output logic [ADDR_W-1:0] widx,
  output logic              rd_pend,
  output logic              wr_pend,
  output logic              rd_fire,
  output logic              wr_fire
);
  logic ctrl_hit, wdat_hit;
  assign ctrl_hit = bus_wr && (bus_addr == CTRL_ADR);
  assign wdat_hit = bus_wr && (bus_addr == WDAT_ADR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_en <= 1'b0;
      ridx    <= '0;
      widx    <= '0;
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      wdata_q <= '0;
    end else begin
      // command bits live one cycle, then clear
      rd_pend <= ctrl_hit && bus_wdata[RD_BIT];
      wr_pend <= ctrl_hit && bus_wdata[WR_BIT];
      if (ctrl_hit) begin
        mode_en <= bus_wdata[MODE_BIT];
        ridx    <= bus_wdata[RIDX_LSB +: ADDR_W];
        widx    <= bus_wdata[WIDX_LSB +: ADDR_W];
      end
      if (wdat_hit) wdata_q <= bus_wdata;
    end
  end

  assign rd_fire = rd_pend && mode_en;
  assign wr_fire = wr_pend && mode_en;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[RD_BIT]   = rd_pend;
    ctrl_word[WR_BIT]   = wr_pend;
    ctrl_word[MODE_BIT] = mode_en;
    ctrl_word[RIDX_LSB +: ADDR_W] = ridx;
    ctrl_word[WIDX_LSB +: ADDR_W] = widx;
  end
endmodule

// File: rtl/tstwin_bank.sv
module tstwin_bank
  import tstwin_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [ADDR_W-1:0]           widx,
  input  logic [BUS_W-1:0]            wdata,
  input  logic [ADDR_W-1:0]           ridx,
  output logic [MAXW-1:0]             rd_value,
  output logic [(2**ADDR_W)*MAXW-1:0] bank_flat
);
  localparam int unsigned NUM_SLOTS = 2 ** ADDR_W;

  logic [MAXW-1:0] slot [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i < NUM_REGS) begin : g_live
      localparam int unsigned W = reg_width(i);
      localparam logic [MAXW-1:0] INIT = init_value(i);
      localparam logic [MAXW-1:0] MASK = width_mask(W);
      logic [W-1:0]    q;
      logic [MAXW-1:0] nxt;
      logic [MAXW-1:0] ext;
      assign nxt = merge_low(ext, wdata, MASK);
      always_ff @(posedge clk) begin
        if (!rst_n)                                   q <= INIT[W-1:0];
        else if (wr_fire && widx == ADDR_W'(i))       q <= nxt[W-1:0];
      end
      always_comb begin
        ext = '0;
        ext[W-1:0] = q;
      end
      assign slot[i] = ext;
    end else begin : g_empty
      assign slot[i] = '0;
    end
    assign bank_flat[i*MAXW +: MAXW] = slot[i];
  end

  // write-first forwarding for a same-cycle read of the written index
  logic            fwd_hit;
  logic [MAXW-1:0] fwd_val;
  assign fwd_hit = wr_fire && (widx == ridx) && (32'(widx) < NUM_REGS);
  assign fwd_val = merge_low(slot[widx], wdata, width_mask(reg_width(32'(widx))));
  assign rd_value = fwd_hit ? fwd_val : slot[ridx];
endmodule

// File: rtl/tstwin_readback.sv
module tstwin_readback
  import tstwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic [MAXW-1:0]  rd_value,
  output logic [BUS_W-1:0] rb_lo,
  output logic [BUS_W-1:0] rb_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_lo <= '0;
      rb_hi <= '0;
    end else if (rd_fire) begin
      rb_lo <= rd_value[BUS_W-1:0];
      rb_hi <= BUS_W'(rd_value >> BUS_W);
    end
  end
endmodule

// File: rtl/tst_window.sv
module tst_window
  import tstwin_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [BUS_W-1:0]            ctrl_word, wdata_q, rb_lo, rb_hi;
  logic                        mode_en, rd_pend, wr_pend, rd_fire, wr_fire;
  logic [ADDR_W-1:0]           ridx, widx;
  logic [MAXW-1:0]             rd_value;
  logic [(2**ADDR_W)*MAXW-1:0] bank_flat;

  tstwin_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ctrl_word(ctrl_word), .wdata_q(wdata_q),
    .mode_en(mode_en), .ridx(ridx), .widx(widx), .rd_pend(rd_pend),
    .wr_pend(wr_pend), .rd_fire(rd_fire), .wr_fire(wr_fire)
  );

  tstwin_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .widx(widx),
    .wdata(wdata_q), .ridx(ridx), .rd_value(rd_value), .bank_flat(bank_flat)
  );

  tstwin_readback u_rb (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_value(rd_value),
    .rb_lo(rb_lo), .rb_hi(rb_hi)
  );

  always_comb begin
    case (bus_addr)
      CTRL_ADR: bus_rdata = ctrl_word;
      RBLO_ADR: bus_rdata = rb_lo;
      RBHI_ADR: bus_rdata = rb_hi;
      WDAT_ADR: bus_rdata = wdata_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tstwin_chk.sv
module tstwin_chk
  import tstwin_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_wr,
  input logic [BUS_W-1:0]            bus_wdata,
  input logic [BUS_W-1:0]            bus_rdata,
  input logic                        mode_en,
  input logic                        rd_pend,
  input logic                        wr_pend,
  input logic                        rd_fire,
  input logic [ADDR_W-1:0]           ridx,
  input logic [BUS_W-1:0]            rb_lo,
  input logic [BUS_W-1:0]            rb_hi,
  input logic [(2**ADDR_W)*MAXW-1:0] bank_flat
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADR);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_ADR) |-> (bus_rdata[13:11] == 3'b000));

  // R3
  rd_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !(ctrl_wr && bus_wdata[RD_BIT])) |=> !rd_pend);

  // R3
  wr_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !(ctrl_wr && bus_wdata[WR_BIT])) |=> !wr_pend);

  // R7
  disabled_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !mode_en) |=> $stable(bank_flat));

  // R8
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> ($stable(rb_lo) && $stable(rb_hi)));

  // R5
  narrow_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && reg_width(32'(ridx)) <= BUS_W) |=> (rb_hi == '0));
endmodule

bind tst_window tstwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_en(mode_en),
  .rd_pend(rd_pend), .wr_pend(wr_pend), .rd_fire(rd_fire), .ridx(ridx),
  .rb_lo(rb_lo), .rb_hi(rb_hi), .bank_flat(bank_flat)
);

// File: tb/sim_tst_window.sv
`timescale 1ns/1ps
module sim_tst_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_CTRL = 5'd20, A_LO = 5'd21, A_HI = 5'd22, A_WD = 5'd23;
  localparam logic [15:0] EN = 16'h0400;

  // {index, write data, expected low, expected high}
  localparam logic [63:0] VEC [7] = '{
    64'h0000_FFFF_001F_0000,   // 5-bit
    64'h0002_1234_1234_0004,   // 19-bit, upper kept from reset
    64'h000D_BEEF_BEEF_C0D3,   // 32-bit
    64'h001D_8001_8001_0000,   // exactly 16-bit
    64'h0006_FFFF_7FFF_0000,   // 15-bit
    64'h001F_0F0F_0F0F_00C1,   // 30-bit
    64'h0004_0007_0001_0000    // 1-bit
  };

  tst_window u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_cmd(logic [15:0] d);
    bus_write(A_CTRL, d);
    @(negedge clk);
  endtask

  task automatic read_pair(output logic [15:0] lo, output logic [15:0] hi);
    bus_read(A_LO, lo);
    bus_read(A_HI, hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, lo, hi;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    bus_read(A_CTRL, v); check("R1 ctrl", v, 16'h0000);
    bus_read(A_WD, v);   check("R1 wdata", v, 16'h0000);
    bus_read(A_LO, v);   check("R1 rb_lo", v, 16'h0000);
    bus_read(A_HI, v);   check("R1 rb_hi", v, 16'h0000);

    // R2 reserved bits discarded
    bus_write(A_CTRL, 16'h3FFF);
    bus_read(A_CTRL, v); check("R2 ctrl layout", v, 16'h07FF);

    // R4 R5 R6 R11 vector walk
    for (int k = 0; k < 7; k++) begin
      bus_write(A_WD, VEC[k][47:32]);
      do_cmd(16'h4000 | EN | VEC[k][52:48]);
      do_cmd(16'h8000 | EN | (VEC[k][63:48] << 5));
      read_pair(lo, hi);
      check($sformatf("R4/R11 lo idx%0d", VEC[k][63:48]), lo, VEC[k][31:16]);
      check($sformatf("R5/R6 hi idx%0d", VEC[k][63:48]), hi, VEC[k][15:0]);
    end

    // R3 command bit visible one cycle, then clears; reg3 reset value (R6)
    bus_write(A_CTRL, 16'h8000 | EN | (16'd3 << 5));
    bus_read(A_CTRL, v); check("R3 rd bit set", v, 16'h8460);
    @(negedge clk);
    bus_read(A_CTRL, v); check("R3 rd bit cleared", v, 16'h0460);
    read_pair(lo, hi);
    check("R6 reset lo idx3", lo, 16'h5A5D);
    check("R6 reset hi idx3", hi, 16'h00DD);

    // R7 disabled mode
    bus_write(A_WD, 16'h1111);
    do_cmd(16'h4000);
    bus_read(A_CTRL, v); check("R7 wr bit cleared", v, 16'h0000);
    do_cmd(16'h8000 | (16'd13 << 5));
    read_pair(lo, hi);
    check("R7 snapshot lo kept", lo, 16'h5A5D);
    check("R7 snapshot hi kept", hi, 16'h00DD);
    do_cmd(16'h8000 | EN);
    read_pair(lo, hi);
    check("R7 bank unchanged", lo, 16'h001F);

    // R8 snapshot persists
    do_cmd(16'h8000 | EN | (16'd13 << 5));
    bus_write(A_WD, 16'h0123);
    do_cmd(16'h4000 | EN | 16'd13);
    read_pair(lo, hi);
    check("R8 lo held", lo, 16'hBEEF);
    check("R8 hi held", hi, 16'hC0D3);
    do_cmd(16'h8000 | EN | (16'd13 << 5));
    read_pair(lo, hi);
    check("R8 new lo", lo, 16'h0123);

    // R9 write before read in one command
    bus_write(A_WD, 16'hA5A5);
    do_cmd(16'hC000 | EN | (16'd7 << 5) | 16'd7);
    read_pair(lo, hi);
    check("R9 lo", lo, 16'hA5A5);
    check("R9 hi", hi, 16'h0019);

    // R10 write-data readable, readback not writable
    bus_write(A_WD, 16'hCAFE);
    bus_read(A_WD, v); check("R10 wdata", v, 16'hCAFE);
    bus_write(A_LO, 16'hFFFF);
    bus_write(A_HI, 16'hFFFF);
    read_pair(lo, hi);
    check("R10 rb_lo ignores write", lo, 16'hA5A5);
    check("R10 rb_hi ignores write", hi, 16'h0019);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule